// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps a small processor core in reset after power-on, and after a wake-up from sleep, until the supply and the clock have had time to settle. A power-on pulse starts the sequence. A power-up timer then counts ticks of a slow internal RC timebase. After it, an oscillator start-up counter counts cycles of the main oscillator. Each stage may be skipped: the power-up timer depends on a configuration bit, and the start-up counter depends on the oscillator mode and on the cause of the wake-up. The external reset pin is active low and asynchronous. It is synchronized, and it gates only the final release of the core. It never restarts a timer.

All inputs are plain control strobes or levels in one system clock domain. Both tick inputs are single-cycle enables. The block has no data stream, so it has no valid/ready interface and no back-pressure. The core-reset output and the running flag are decoded from a registered state.

Top module: `pwrseq_top`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is 1 and `running` is 0. A new pulse at any time restarts the whole sequence, and both counters start again from zero.
- R2: When `pu_timer_off` is 0, the first clock after `por_pulse` falls starts the power-up timer. `core_rst` stays 1 until exactly `PU_TICKS` `rc_tick` strobes have been seen.
- R3: `osc_tick` strobes have no effect on the power-up timer, and `rc_tick` strobes have no effect on the start-up counter.
- R4: The start-up counter runs only after the power-up timer has finished or been skipped, and only in a crystal mode (`osc_mode` 0, 1 or 2). It holds reset for exactly `OSC_CYCLES` `osc_tick` strobes.
- R5: In an RC mode (`osc_mode` 4 or 5; any other code counts as RC), the start-up counter is skipped. With `pu_timer_off` = 1 as well, no tick is needed at all, and `running` rises on the third clock after `por_pulse` falls.
- R6: A wake-up from sleep never runs the power-up timer. In a crystal mode it runs the start-up counter; in an RC mode the core runs on the next clock.
- R7: If `ext_rst_n` is held low past the end of the timers, `core_rst` stays 1. The core runs on the third clock after the pin rises, because the pin passes through a two-stage synchronizer.
- R8: Pulling `ext_rst_n` low while the core runs reasserts `core_rst` on the third clock. On release the core runs again on the third clock, with no timer.
- R9: `sleep_req` in the running state enters sleep, where `core_rst` = 0 and `running` = 0. If a low synchronized pin and `wake_req` arrive in the same clock, the pin wins, and no start-up count follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous assert |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sleep_req | input | 1 | Core requests sleep (strobe) |
| wake_req | input | 1 | Wake-up event from sleep (strobe) |
| osc_mode | input | 3 | 0/1/2 crystal modes, 4/5 RC modes |
| pu_timer_off | input | 1 | Configuration bit: 0 runs the power-up timer, 1 skips it |
| rc_tick | input | 1 | One strobe per slow RC timebase tick |
| osc_tick | input | 1 | One strobe per main-oscillator cycle |
| core_rst | output | 1 | Holds the core in reset |
| running | output | 1 | Core is released and executing |

## Verification
Two events can fall in the same clock: the synchronized pin going low, and a wake request while the block sleeps. The bench drops the pin, waits two clocks until the synchronizer output is low, and raises `wake_req` for the clock in which the state machine first sees the low pin. It then releases the pin without giving any oscillator tick. The core must run three clocks later, which shows that the pin won and that no start-up count was started.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_POR     = 3'd0,
    ST_PWRUP   = 3'd1,
    ST_OSCWAIT = 3'd2,
    ST_PINWAIT = 3'd3,
    ST_RUN     = 3'd4,
    ST_SLEEP   = 3'd5
  } seq_state_t;

  localparam logic [2:0] OSC_LP    = 3'd0;
  localparam logic [2:0] OSC_XT    = 3'd1;
  localparam logic [2:0] OSC_HS    = 3'd2;
  localparam logic [2:0] OSC_INTRC = 3'd4;
  localparam logic [2:0] OSC_EXTRC = 3'd5;

  function automatic logic is_crystal(input logic [2:0] m);
    return (m == OSC_LP) || (m == OSC_XT) || (m == OSC_HS);
  endfunction
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain[0] <= 1'b0;
          else      chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain[g] <= 1'b0;
          else      chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_tickcnt.sv
module pwrseq_tickcnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic arst,
  input  logic en,
  input  logic tick,
  output logic done
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)         cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (tick)    cnt <= cnt + W'(1);
  end

  assign done = en && tick && (cnt == LAST);

  // R3 / R4: count never passes its limit while enabled
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (arst)
    en |-> (cnt <= LAST));
  // R3: a cleared counter stays at zero until enabled again
  a_r3_cnt_idle: assert property (@(posedge clk) disable iff (arst)
    !en |=> (cnt == '0));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int PU_TICKS    = 72,
  parameter int OSC_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       ext_rst_n,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic [2:0] osc_mode,
  input  logic       pu_timer_off,
  input  logic       rc_tick,
  input  logic       osc_tick,
  output logic       core_rst,
  output logic       running
);
  seq_state_t state, nxt;
  logic pin_ok, pu_done, osc_done, xtal;

  pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst(por_pulse), .din(ext_rst_n), .dout(pin_ok)
  );

  pwrseq_tickcnt #(.LIMIT(PU_TICKS)) u_pu (
    .clk(clk), .arst(por_pulse), .en(state == ST_PWRUP),
    .tick(rc_tick), .done(pu_done)
  );

  pwrseq_tickcnt #(.LIMIT(OSC_CYCLES)) u_osc (
    .clk(clk), .arst(por_pulse), .en(state == ST_OSCWAIT),
    .tick(osc_tick), .done(osc_done)
  );

  assign xtal = is_crystal(osc_mode);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_POR: begin
        if (!pu_timer_off) nxt = ST_PWRUP;
        else if (xtal)     nxt = ST_OSCWAIT;
        else               nxt = ST_PINWAIT;
      end
      ST_PWRUP:   if (pu_done)  nxt = xtal ? ST_OSCWAIT : ST_PINWAIT;
      ST_OSCWAIT: if (osc_done) nxt = ST_PINWAIT;
      ST_PINWAIT: if (pin_ok)   nxt = ST_RUN;
      ST_RUN: begin
        if (!pin_ok)        nxt = ST_PINWAIT;
        else if (sleep_req) nxt = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!pin_ok)       nxt = ST_PINWAIT;
        else if (wake_req) nxt = xtal ? ST_OSCWAIT : ST_RUN;
      end
      default: nxt = ST_POR;
    endcase
  end

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) state <= ST_POR;
    else           state <= nxt;
  end

  assign running  = (state == ST_RUN);
  assign core_rst = !((state == ST_RUN) || (state == ST_SLEEP));

  // R2: configuration bit set means the power-up timer is never entered
  a_r2_pu_skip: assert property (@(posedge clk) disable iff (por_pulse)
    (state == ST_POR && pu_timer_off) |=> (state != ST_PWRUP));
  // R5: the start-up counter is never active in an RC mode
  a_r5_rc_no_osc: assert property (@(posedge clk) disable iff (por_pulse)
    (state == ST_OSCWAIT) |-> xtal);
  // R6: leaving sleep never enters the power-up timer
  a_r6_wake_no_pu: assert property (@(posedge clk) disable iff (por_pulse)
    (state == ST_SLEEP) |=> (state != ST_PWRUP));
  // R8: a low synchronized pin while running puts the core back in reset
  a_r8_pin_rst: assert property (@(posedge clk) disable iff (por_pulse)
    (state == ST_RUN && !pin_ok) |=> core_rst);
  // R9: a low pin beats a same-cycle wake request
  a_r9_pin_wins: assert property (@(posedge clk) disable iff (por_pulse)
    (state == ST_SLEEP && !pin_ok && wake_req) |=> (state == ST_PINWAIT));
  // R4: the start-up counter ends only into the pin wait
  a_r4_osc_exit: assert property (@(posedge clk) disable iff (por_pulse)
    (state == ST_OSCWAIT && osc_done) |=> (state == ST_PINWAIT));
endmodule

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int PU = 8;
  localparam int OSCN = 1024;

  logic clk = 1'b0;
  logic por_pulse = 1'b0;
  logic ext_rst_n = 1'b1;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic [2:0] osc_mode = 3'd1;
  logic pu_timer_off = 1'b0;
  logic rc_tick = 1'b0;
  logic osc_tick = 1'b0;
  logic core_rst, running;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrseq_top #(.PU_TICKS(PU), .OSC_CYCLES(OSCN)) u0 (
    .clk(clk), .por_pulse(por_pulse), .ext_rst_n(ext_rst_n),
    .sleep_req(sleep_req), .wake_req(wake_req), .osc_mode(osc_mode),
    .pu_timer_off(pu_timer_off), .rc_tick(rc_tick), .osc_tick(osc_tick),
    .core_rst(core_rst), .running(running)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind 0: rc ticks, kind 1: osc ticks; noisy adds one tick of the other kind first
  task automatic ticks(input int kind, input int n, input bit noisy);
    for (int i = 0; i < n; i++) begin
      if (noisy) begin
        @(negedge clk);
        if (kind == 0) osc_tick = 1'b1; else rc_tick = 1'b1;
      end
      @(negedge clk);
      osc_tick = 1'b0; rc_tick = 1'b0;
      if (kind == 0) rc_tick = 1'b1; else osc_tick = 1'b1;
      @(negedge clk);
      rc_tick = 1'b0; osc_tick = 1'b0;
    end
  endtask

  task automatic do_por(input logic [2:0] mode, input logic off);
    @(negedge clk);
    por_pulse = 1'b1; osc_mode = mode; pu_timer_off = off;
    cycles(3);
    por_pulse = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    por_pulse = 1'b1;
    cycles(2);
    chk("R1 reset core_rst", core_rst, 1'b1);
    chk("R1 reset running", running, 1'b0);
  endtask

  task automatic t_full_chain();
    do_por(3'd1, 1'b0);
    cycles(1);
    ticks(0, PU-1, 1'b1);
    chk("R2 pu timer still holding", core_rst, 1'b1);
    ticks(0, 1, 1'b1);
    chk("R2 after pu, in start-up count", core_rst, 1'b1);
    ticks(1, OSCN-1, 1'b1);
    chk("R4 start-up one short", core_rst, 1'b1);
    chk("R3 rc ticks ignored during start-up", running, 1'b0);
    ticks(1, 1, 1'b0);
    chk("R4 pin wait still in reset", running, 1'b0);
    cycles(1);
    chk("R4 chain released", running, 1'b1);
    chk("R4 chain core_rst", core_rst, 1'b0);
  endtask

  task automatic t_rc_zero();
    do_por(3'd4, 1'b1);
    cycles(2);
    chk("R5 zero time-out, clock 2", running, 1'b0);
    cycles(1);
    chk("R5 zero time-out, clock 3", running, 1'b1);
  endtask

  task automatic t_rc_pu_only();
    do_por(3'd5, 1'b0);
    cycles(1);
    ticks(0, PU, 1'b0);
    chk("R5 rc mode no start-up, pin wait", running, 1'b0);
    cycles(1);
    chk("R5 rc mode released after pu only", running, 1'b1);
  endtask

  task automatic t_xtal_osc_only();
    do_por(3'd2, 1'b1);
    cycles(1);
    ticks(1, OSCN-1, 1'b0);
    chk("R4 pu skipped, start-up one short", core_rst, 1'b1);
    ticks(1, 1, 1'b0);
    cycles(1);
    chk("R4 pu skipped, released", running, 1'b1);
  endtask

  task automatic t_pin_held();
    @(negedge clk);
    ext_rst_n = 1'b0;
    do_por(3'd0, 1'b0);
    cycles(1);
    ticks(0, PU, 1'b0);
    ticks(1, OSCN, 1'b0);
    cycles(5);
    chk("R7 pin low past expiry", core_rst, 1'b1);
    ext_rst_n = 1'b1;
    cycles(2);
    chk("R7 synchronizer delay", running, 1'b0);
    cycles(1);
    chk("R7 runs on third clock", running, 1'b1);
  endtask

  task automatic t_pin_pulse_run();
    // precondition: running
    ext_rst_n = 1'b0;
    cycles(2);
    chk("R8 pin low, not yet seen", running, 1'b1);
    cycles(1);
    chk("R8 pin low reasserts reset", core_rst, 1'b1);
    ext_rst_n = 1'b1;
    cycles(2);
    chk("R8 release not yet seen", running, 1'b0);
    cycles(1);
    chk("R8 resumes with no timer", running, 1'b1);
  endtask

  task automatic t_sleep_xtal();
    do_por(3'd1, 1'b1);
    cycles(1);
    ticks(1, OSCN, 1'b0);
    cycles(1);
    chk("R9 running before sleep", running, 1'b1);
    sleep_req = 1'b1;
    cycles(1);
    sleep_req = 1'b0;
    chk("R9 sleep core_rst", core_rst, 1'b0);
    chk("R9 sleep running", running, 1'b0);
    ticks(0, PU + 2, 1'b0);
    chk("R6 rc ticks in sleep do nothing", running, 1'b0);
    wake_req = 1'b1;
    cycles(1);
    wake_req = 1'b0;
    chk("R6 wake enters start-up count", core_rst, 1'b1);
    ticks(1, OSCN, 1'b0);
    cycles(1);
    chk("R6 wake released without pu timer", running, 1'b1);
  endtask

  task automatic t_sleep_rc();
    do_por(3'd4, 1'b1);
    cycles(3);
    sleep_req = 1'b1;
    cycles(1);
    sleep_req = 1'b0;
    chk("R9 rc sleep", running, 1'b0);
    wake_req = 1'b1;
    cycles(1);
    wake_req = 1'b0;
    chk("R6 rc wake runs next clock", running, 1'b1);
  endtask

  task automatic t_collision();
    do_por(3'd1, 1'b1);
    cycles(1);
    ticks(1, OSCN, 1'b0);
    cycles(1);
    sleep_req = 1'b1;
    cycles(1);
    sleep_req = 1'b0;
    ext_rst_n = 1'b0;
    cycles(2);
    wake_req = 1'b1;
    cycles(1);
    wake_req = 1'b0;
    chk("R9 collision core_rst", core_rst, 1'b1);
    ext_rst_n = 1'b1;
    cycles(3);
    chk("R9 pin won, no start-up count", running, 1'b1);
  endtask

  task automatic t_por_restart();
    do_por(3'd1, 1'b1);
    cycles(1);
    ticks(1, 600, 1'b0);
    @(negedge clk);
    por_pulse = 1'b1;
    #1;
    chk("R1 new pulse forces reset", core_rst, 1'b1);
    cycles(2);
    por_pulse = 1'b0;
    cycles(1);
    ticks(1, OSCN-1, 1'b0);
    chk("R1 counter restarted from zero", core_rst, 1'b1);
    ticks(1, 1, 1'b0);
    cycles(1);
    chk("R1 restarted chain releases", running, 1'b1);
  endtask

  initial begin
    #1 por_pulse = 1'b1;
    t_reset_state();
    t_full_chain();
    t_rc_zero();
    t_rc_pu_only();
    t_xtal_osc_only();
    t_pin_held();
    t_pin_pulse_run();
    t_sleep_xtal();
    t_sleep_rc();
    t_collision();
    t_por_restart();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule